// File: doc/BRIEF.md
# Integer Arithmetic Logic Unit with Flag Outputs

This block is the combinational arithmetic logic unit of a 32-bit integer datapath. It receives two operands and a three-bit function code in the same cycle. It returns a result word together with a zero flag and a signed overflow flag. The supported functions are bitwise AND, bitwise OR, addition, subtraction and a signed less-than comparison. Equality branches run a subtraction and test the zero flag.

A single ripple adder built from repeated one-bit slices serves addition, subtraction and comparison. The top bit of the function code does two jobs: it inverts the second operand and it sets the carry into bit 0. The comparison takes the sign of the difference and corrects it with the overflow term, then places that bit at result bit 0. Every other result bit is zero for a comparison.

Top module: `alu_core`

## Requirements
- R1: Code 3'b000 returns the bitwise AND of the two operands.
- R2: Code 3'b001 returns the bitwise OR of the two operands.
- R3: Code 3'b010 returns the sum of the two operands modulo 2^32.
- R4: Code 3'b110 returns the first operand minus the second operand modulo 2^32.
- R5: Code 3'b111 returns 1 when the first operand is less than the second as signed two's complement values, and 0 otherwise. Bits 31..1 of the result are always 0, and the answer stays correct when the internal difference overflows.
- R6: For the five defined codes, the zero flag is 1 exactly when all 32 result bits are 0.
- R7: For code 3'b010, the overflow flag is 1 exactly when both operands have the same sign and the sum's sign differs from it. When the operand signs differ, the flag is 0.
- R8: For code 3'b110, the overflow flag is 1 exactly when the operand signs differ and the difference's sign differs from the first operand's sign. When the operand signs match, the flag is 0.
- R9: For codes 3'b000, 3'b001 and 3'b111, the overflow flag is 0.
- R10: For codes 3'b011, 3'b100 and 3'b101, the result is 0 and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| op | input | 3 | Function code |
| res | output | 32 | Result word |
| zero | output | 1 | Result-is-zero flag for the defined codes |
| ovf | output | 1 | Signed overflow flag for add and subtract |

## Verification
The hardest case to reach is a comparison in which the internal difference overflows. In that case the raw sign bit gives the wrong answer, and only the overflow correction makes the result right. Random operands land there rarely, so the stimulus pairs the most negative and most positive values with small operands of the opposite sign. The same extreme pairs also drive a sum that wraps to exactly zero while overflow is set, and a difference that overflows in each direction. Randomized vectors across all eight codes then cover the ordinary cases.

// File: rtl/alu_core.sv
module alu_core #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic [2:0]       op,
  output logic [WIDTH-1:0] res,
  output logic             zero,
  output logic             ovf
);
  localparam int MSB = WIDTH - 1;

  logic             binv;
  logic [WIDTH-1:0] bsel;
  logic [WIDTH-1:0] sum;
  logic [WIDTH:0]   carry;
  logic             ovf_raw;
  logic             set_lt;
  logic             arith;
  logic             known;

  assign binv     = op[2];
  assign bsel     = opb ^ {WIDTH{binv}};
  assign carry[0] = binv;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    assign sum[i]     = opa[i] ^ bsel[i] ^ carry[i];
    assign carry[i+1] = (opa[i] & bsel[i]) | (opa[i] & carry[i]) | (bsel[i] & carry[i]);
  end

  assign ovf_raw = carry[WIDTH] ^ carry[MSB];
  assign set_lt  = sum[MSB] ^ ovf_raw;

  always_comb begin
    res   = '0;
    known = 1'b1;
    arith = 1'b0;
    case (op)
      3'b000: res = opa & opb;
      3'b001: res = opa | opb;
      3'b010: begin res = sum; arith = 1'b1; end
      3'b110: begin res = sum; arith = 1'b1; end
      3'b111: res = {{MSB{1'b0}}, set_lt};
      default: known = 1'b0;
    endcase
  end

  assign zero = known & ~|res;
  assign ovf  = arith & ovf_raw;
endmodule

module alu_core_chk #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] opa,
  input logic [WIDTH-1:0] opb,
  input logic [2:0]       op,
  input logic [WIDTH-1:0] res,
  input logic             zero,
  input logic             ovf
);
  localparam int MSB = WIDTH - 1;
  logic [WIDTH-1:0] add_ref;
  logic [WIDTH-1:0] sub_ref;
  logic             lt_ref;
  logic             defined;

  assign add_ref = opa + opb;
  assign sub_ref = opa - opb;
  assign lt_ref  = $signed(opa) < $signed(opb);
  assign defined = (op == 3'b000) || (op == 3'b001) || (op == 3'b010) || (op == 3'b110) || (op == 3'b111);

  always_comb begin
    if (op == 3'b000) p_and_r1: assert (res == (opa & opb));
    if (op == 3'b001) p_or_r2: assert (res == (opa | opb));
    if (op == 3'b010) p_add_r3: assert (res == add_ref);
    if (op == 3'b110) p_sub_r4: assert (res == sub_ref);
    if (op == 3'b111) p_slt_r5: assert (res == {{MSB{1'b0}}, lt_ref});
    if (defined) p_zero_r6: assert (zero == (res == '0));
    if (op == 3'b010) p_ovf_add_r7: assert (ovf == ((opa[MSB] == opb[MSB]) && (add_ref[MSB] != opa[MSB])));
    if (op == 3'b110) p_ovf_sub_r8: assert (ovf == ((opa[MSB] != opb[MSB]) && (sub_ref[MSB] != opa[MSB])));
    if (op == 3'b000 || op == 3'b001 || op == 3'b111) p_no_overflow_r9: assert (!ovf);
    if (!defined) p_unused_r10: assert (res == '0 && !zero && !ovf);
  end
endmodule

bind alu_core alu_core_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/test_alu_core.sv
module test_alu_core;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [31:0] r;
    logic        z;
    logic        v;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] opa = '0;
  logic [31:0] opb = '0;
  logic [2:0]  op  = 3'b000;
  logic [31:0] res;
  logic        zero;
  logic        ovf;

  exp_t q[$];
  int   n_chk  = 0;
  int   n_fail = 0;
  bit   done   = 1'b0;

  alu_core i_alu_core (.opa(opa), .opb(opb), .op(op), .res(res), .zero(zero), .ovf(ovf));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic drive(input logic [31:0] a, input logic [31:0] b, input logic [2:0] c, input string tag);
    exp_t e;
    logic [31:0] s;
    e.tag = tag;
    e.v = 1'b0;
    case (c)
      3'b000: e.r = a & b;
      3'b001: e.r = a | b;
      3'b010: begin s = a + b; e.r = s; e.v = (a[31] == b[31]) && (s[31] != a[31]); end
      3'b110: begin s = a - b; e.r = s; e.v = (a[31] != b[31]) && (s[31] != a[31]); end
      3'b111: e.r = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      default: e.r = '0;
    endcase
    e.z = (c == 3'b011 || c == 3'b100 || c == 3'b101) ? 1'b0 : (e.r == '0);
    @(posedge clk);
    #1;
    opa = a; opb = b; op = c;
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (!rst && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_chk++;
      if (res !== e.r || zero !== e.z || ovf !== e.v) begin
        n_fail++;
        $display("FAIL %s: got res=%h zero=%b ovf=%b expected res=%h zero=%b ovf=%b",
                 e.tag, res, zero, ovf, e.r, e.z, e.v);
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    rst = 1'b0;
    drive(32'h0, 32'h0, 3'b000, "R1 R6 idle zero");
    drive(32'hF0F0_1234, 32'h0FF0_FF00, 3'b000, "R1 and");
    drive(32'hAAAA_AAAA, 32'h5555_5555, 3'b000, "R1 R6 and disjoint");
    drive(32'hF000_0000, 32'h0000_000F, 3'b001, "R2 or");
    drive(32'h7FFF_FFFF, 32'h7FFF_FFFF, 3'b000, "R9 and no ovf");
    drive(32'h8000_0000, 32'h8000_0000, 3'b001, "R9 or no ovf");
    drive(32'h0000_0005, 32'h0000_0007, 3'b010, "R3 add");
    drive(32'hFFFF_FFFF, 32'h0000_0001, 3'b010, "R3 R6 R7 add wrap zero");
    drive(32'h7FFF_FFFF, 32'h0000_0001, 3'b010, "R7 add pos ovf");
    drive(32'h8000_0000, 32'h8000_0000, 3'b010, "R7 R6 add neg ovf zero");
    drive(32'h8000_0000, 32'h7FFF_FFFF, 3'b010, "R7 mixed signs");
    drive(32'h0000_0009, 32'h0000_0003, 3'b110, "R4 sub");
    drive(32'h1234_5678, 32'h1234_5678, 3'b110, "R4 R6 beq equal");
    drive(32'h0000_0003, 32'h0000_0009, 3'b110, "R4 sub negative");
    drive(32'h8000_0000, 32'h0000_0001, 3'b110, "R8 sub neg minus pos");
    drive(32'h7FFF_FFFF, 32'hFFFF_FFFF, 3'b110, "R8 sub pos minus neg");
    drive(32'hFFFF_FFFF, 32'hFFFF_FFFE, 3'b110, "R8 same signs");
    drive(32'hFFFF_FFFF, 32'h0000_0001, 3'b111, "R5 slt neg lt pos");
    drive(32'h0000_0001, 32'hFFFF_FFFF, 3'b111, "R5 R6 slt pos ge neg");
    drive(32'h8000_0000, 32'h0000_0001, 3'b111, "R5 R9 slt ovf true");
    drive(32'h7FFF_FFFF, 32'h8000_0000, 3'b111, "R5 R9 slt ovf false");
    drive(32'h0000_0004, 32'h0000_0004, 3'b111, "R5 slt equal");
    drive(32'h7FFF_FFFF, 32'h0000_0001, 3'b011, "R10 code 011");
    drive(32'h8000_0000, 32'h0000_0001, 3'b100, "R10 code 100");
    drive(32'h0000_0000, 32'h0000_0000, 3'b101, "R10 code 101");
    for (int k = 0; k < 400; k++) begin
      logic [31:0] a;
      logic [31:0] b;
      a = $urandom();
      b = $urandom();
      if (k % 5 == 0) b = a;
      if (k % 7 == 0) a[31] = ~b[31];
      drive(a, b, 3'($urandom_range(0, 7)), "R3 R4 R5 random");
    end
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule